// File: doc/BRIEF.md
# Consumer Clock Source Selector and Divider

This block feeds six clock consumers from a shared set of rate ticks. Each consumer picks one input, which can be the auxiliary PLL tick or one of six generator ticks, or it can be switched off. The selected tick stream then goes through a small divider, and the result is a one-cycle output tick for that consumer. Everything runs in a single system clock domain. Inputs and outputs are single-cycle enable pulses, not clocks.

All six selectors are configured through one 32-bit control word. Each consumer owns a 5-bit field in that word:

- The upper three bits of the field choose the source. A value of zero disables the consumer.
- The lower two bits index a divide table.

Software can set the word in two ways:

- Write the whole word.
- Issue a divide request that carries a fixed-point ratio for one consumer. The block rounds the ratio, maps it onto a table code and updates only that consumer's divide bits. An impossible ratio is refused and flagged.

A parameter picks between two divide tables. The standard table has no divide-by-3. The extended table provides it.

Top module: `clk_src_mux`

## Requirements
- R1: After reset the control word reads 0, and every enable flag, output tick and error flag is low.
- R2: A write with `wrEn` loads all 32 bits, and `rdData` returns them on the next cycle. Consumer i owns bits [5i+4:5i], with source in [5i+4:5i+2] and divide code in [5i+1:5i]. Bits 31:30 are storage only.
- R3: Source code 0 means off, code 1 selects `auxTick`, and codes 2 to 7 select `genTick[0]` to `genTick[5]`.
- R4: `consEnabled[i]` is high exactly when consumer i's 3-bit source field in the control word is nonzero.
- R5: Divide code c gives ratio N. With `EXT_TABLE`=0 the codes 0,1,2,3 give N = 1,4,1,2. With `EXT_TABLE`=1 they give N = 1,4,3,2. An enabled consumer emits one output tick for every N selected source ticks, counted from its last boundary.
- R6: While a consumer's source field is 0, its output tick stays low and its divide count is cleared. After re-enabling, the first output comes after N fresh source ticks.
- R7: A field change while the consumer is running takes effect on the cycle of its next output tick. A change from off, or to off, takes effect one cycle after the word changes.
- R8: A divide request gives `reqRatio` as an unsigned number with `FRAC_W` fraction bits (4 by default). It is rounded to the nearest integer, with halves rounding up. Rounded values 1, 2, 3 and 4 write codes 0, 3, 2 and 1 into consumer `reqSel`'s divide bits, and no other bits change.
- R9: A request whose rounded value is 0 or above 4, or whose `reqSel` is above 5, leaves the word unchanged. It raises `reqErr` for exactly one cycle, on the cycle after the request.
- R10: With `EXT_TABLE`=0, a rounded request of 3 writes code 1 (divide by 4).
- R11: When `wrEn` and `reqValid` arrive in the same cycle, the word takes `wrData` and the request's update is lost. A refused request still raises `reqErr`.
- R12: A consumer's output tick rises on the cycle after the source tick that completes its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Whole-word write strobe |
| wrData | input | 32 | Control word to write |
| rdData | output | 32 | Current control word |
| reqValid | input | 1 | Divide request strobe |
| reqSel | input | 3 | Consumer addressed by the request |
| reqRatio | input | RATIO_W (8) | Requested divide ratio, FRAC_W fraction bits |
| reqErr | output | 1 | One-cycle pulse when a request is refused |
| auxTick | input | 1 | Auxiliary PLL rate tick |
| genTick | input | 6 | Generator rate ticks |
| consEnabled | output | 6 | Per-consumer enable flag |
| consTick | output | 6 | Per-consumer divided output tick |

## Verification
Two of the block's functions can fall on the same cycle:

- A whole-word write and a divide request can hit the control word together. The bench provokes this by issuing both in one cycle with random data and ratios, many times over. It judges that the word equals the written data and that `reqErr` still follows the request's own validity.
- A field change can arrive on the very cycle a consumer reaches its output boundary. Random writes at random spacing against random source ticks create this case. The bench compares each consumer's tick stream, cycle by cycle, against a counting model built from R5 to R7.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int NUM_CONS = 6;
  localparam int GEN_N    = 6;
  localparam int SRC_W    = 3;
  localparam int CODE_W   = 2;
  localparam int FIELD_W  = SRC_W + CODE_W;
  localparam int REG_W    = 32;
  localparam int USED_W   = NUM_CONS * FIELD_W;
  localparam int DIV_W    = 3;

  typedef struct packed {
    logic [REG_W-1:0] cfg;
    logic             errPulse;
  } ctlOut_t;

  // Ratio for a divide code: standard {1,4,1,2}, extended {1,4,3,2}
  function automatic logic [DIV_W-1:0] divFor(input logic [CODE_W-1:0] code, input bit ext);
    case (code)
      2'd0:    divFor = 3'd1;
      2'd1:    divFor = 3'd4;
      2'd2:    divFor = ext ? 3'd3 : 3'd1;
      default: divFor = 3'd2;
    endcase
  endfunction

  // Table code for a rounded ratio 1..4 (3 folds to 4 without divide-by-3)
  function automatic logic [CODE_W-1:0] codeFor(input logic [DIV_W-1:0] ratio, input bit ext);
    case (ratio)
      3'd2:    codeFor = 2'd3;
      3'd3:    codeFor = ext ? 2'd2 : 2'd1;
      3'd4:    codeFor = 2'd1;
      default: codeFor = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
#(
  parameter bit EXT_TABLE = 1'b1,
  parameter int RATIO_W   = 8,
  parameter int FRAC_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic               reqValid,
  input  logic [SRC_W-1:0]   reqSel,
  input  logic [RATIO_W-1:0] reqRatio,
  output ctlOut_t            ctlOut
);
  localparam int SUM_W = RATIO_W + 1;
  localparam int RND_W = SUM_W - FRAC_W;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC_W - 1);

  logic [REG_W-1:0] cfg, cfgNext;
  logic [SUM_W-1:0] roundSum;
  logic [RND_W-1:0] rounded;
  logic             reject;
  logic             errPulse;
  logic [CODE_W-1:0] newCode;

  always_comb begin
    roundSum = {1'b0, reqRatio} + HALF;
    rounded  = roundSum[SUM_W-1:FRAC_W];
    reject   = (rounded == '0) || (rounded > RND_W'(4)) || (reqSel >= SRC_W'(NUM_CONS));
    newCode  = codeFor(rounded[DIV_W-1:0], EXT_TABLE);
  end

  always_comb begin
    cfgNext = cfg;
    if (wrEn) begin
      cfgNext = wrData;
    end else if (reqValid && !reject) begin
      for (int i = 0; i < NUM_CONS; i++) begin
        if (reqSel == SRC_W'(i)) cfgNext[i*FIELD_W +: CODE_W] = newCode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      errPulse <= 1'b0;
    end else begin
      cfg      <= cfgNext;
      errPulse <= reqValid && reject;
    end
  end

  assign ctlOut.cfg      = cfg;
  assign ctlOut.errPulse = errPulse;

  AST_ERR_KEEPS_REG: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !$past(wrEn)) |-> $stable(cfg)); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse && !reqValid) |=> !errPulse); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (cfg == $past(wrData))); // R11
endmodule

// File: rtl/csm_slice.sv
module csm_slice
  import csm_pkg::*;
#(
  parameter bit EXT_TABLE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] pendField,
  input  logic               auxTick,
  input  logic [GEN_N-1:0]   genTick,
  output logic               tickOut
);
  logic [SRC_W-1:0]  pendSrc, actSrc;
  logic [CODE_W-1:0] pendCode, actCode, cnt;
  logic [DIV_W-1:0]  divisor;
  logic              srcTick, atLast;

  assign pendSrc  = pendField[FIELD_W-1:CODE_W];
  assign pendCode = pendField[CODE_W-1:0];

  always_comb begin
    if (actSrc == '0)             srcTick = 1'b0;
    else if (actSrc == SRC_W'(1)) srcTick = auxTick;
    else                          srcTick = genTick[actSrc - SRC_W'(2)];
    divisor = divFor(actCode, EXT_TABLE);
    atLast  = ({1'b0, cnt} == (divisor - DIV_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSrc  <= '0;
      actCode <= '0;
      cnt     <= '0;
      tickOut <= 1'b0;
    end else begin
      tickOut <= 1'b0;
      if (pendSrc == '0 || actSrc == '0) begin
        actSrc  <= pendSrc;
        actCode <= pendCode;
        cnt     <= '0;
      end else if (srcTick) begin
        if (atLast) begin
          tickOut <= 1'b1;
          cnt     <= '0;
          actSrc  <= pendSrc;
          actCode <= pendCode;
        end else begin
          cnt <= cnt + CODE_W'(1);
        end
      end
    end
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (pendSrc == '0) |=> !tickOut); // R6
  AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> $past(srcTick)); // R12
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, cnt} < divisor)); // R5
  AST_HOLD_MIDWAY: assert property (@(posedge clk) disable iff (!rstN)
    (actSrc != '0 && pendSrc != '0 && !(srcTick && atLast)) |=> $stable(actSrc)); // R7
endmodule

// File: rtl/csm_datapath.sv
module csm_datapath
  import csm_pkg::*;
#(
  parameter bit EXT_TABLE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [USED_W-1:0]   cfgUsed,
  input  logic                auxTick,
  input  logic [GEN_N-1:0]    genTick,
  output logic [NUM_CONS-1:0] consTick
);
  for (genvar i = 0; i < NUM_CONS; i++) begin : gSlice
    csm_slice #(.EXT_TABLE(EXT_TABLE)) uSlice (
      .clk       (clk),
      .rstN      (rstN),
      .pendField (cfgUsed[i*FIELD_W +: FIELD_W]),
      .auxTick   (auxTick),
      .genTick   (genTick),
      .tickOut   (consTick[i])
    );
  end
endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux
  import csm_pkg::*;
#(
  parameter bit EXT_TABLE = 1'b1,
  parameter int RATIO_W   = 8,
  parameter int FRAC_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic               reqValid,
  input  logic [2:0]         reqSel,
  input  logic [RATIO_W-1:0] reqRatio,
  output logic               reqErr,
  input  logic               auxTick,
  input  logic [5:0]         genTick,
  output logic [5:0]         consEnabled,
  output logic [5:0]         consTick
);
  ctlOut_t ctlOut;

  csm_ctrl #(.EXT_TABLE(EXT_TABLE), .RATIO_W(RATIO_W), .FRAC_W(FRAC_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .reqValid (reqValid),
    .reqSel   (reqSel),
    .reqRatio (reqRatio),
    .ctlOut   (ctlOut)
  );

  csm_datapath #(.EXT_TABLE(EXT_TABLE)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .cfgUsed  (ctlOut.cfg[USED_W-1:0]),
    .auxTick  (auxTick),
    .genTick  (genTick),
    .consTick (consTick)
  );

  for (genvar i = 0; i < NUM_CONS; i++) begin : gEn
    assign consEnabled[i] = |ctlOut.cfg[i*FIELD_W + CODE_W +: SRC_W];
  end

  assign rdData = ctlOut.cfg;
  assign reqErr = ctlOut.errPulse;
endmodule

// File: tb/clk_src_mux_test.sv
module clk_src_mux_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic reqValid = 1'b0;
  logic [2:0] reqSel = '0;
  logic [7:0] reqRatio = '0;
  logic auxTick = 1'b0;
  logic [5:0] genTick = '0;

  logic [31:0] rdX, rdS;
  logic errX, errS;
  logic [5:0] enX, enS, tkX, tkS;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  clk_src_mux #(.EXT_TABLE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdX),
    .reqValid(reqValid), .reqSel(reqSel), .reqRatio(reqRatio), .reqErr(errX),
    .auxTick(auxTick), .genTick(genTick), .consEnabled(enX), .consTick(tkX));

  clk_src_mux #(.EXT_TABLE(1'b0)) uutStd (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdS),
    .reqValid(reqValid), .reqSel(reqSel), .reqRatio(reqRatio), .reqErr(errS),
    .auxTick(auxTick), .genTick(genTick), .consEnabled(enS), .consTick(tkS));

  // Reference model, index 0 = standard table, 1 = extended table
  logic [31:0] mReg [2] = '{32'd0, 32'd0};
  logic [5:0]  mTick [2] = '{6'd0, 6'd0};
  logic        mErr [2] = '{1'b0, 1'b0};
  int mSrc [2][6];
  int mCode [2][6];
  int mCnt [2][6];

  function automatic int ratioOf(int code, int ext);
    case (code)
      0: return 1;
      1: return 4;
      2: return ext ? 3 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic int codeOf(int r, int ext);
    case (r)
      1: return 0;
      2: return 3;
      3: return ext ? 2 : 1;
      default: return 1;
    endcase
  endfunction

  function automatic bit srcOf(int s, logic a, logic [5:0] g);
    if (s == 0) return 1'b0;
    if (s == 1) return a;
    return g[s-2];
  endfunction

  always @(posedge clk) begin
    for (int e = 0; e < 2; e++) begin
      if (!rstN) begin
        mReg[e] = '0; mTick[e] = '0; mErr[e] = 1'b0;
        for (int i = 0; i < 6; i++) begin mSrc[e][i] = 0; mCode[e][i] = 0; mCnt[e][i] = 0; end
      end else begin
        int rnd;
        bit rej;
        for (int i = 0; i < 6; i++) begin
          int ps, pc;
          ps = int'(mReg[e][i*5+2 +: 3]);
          pc = int'(mReg[e][i*5 +: 2]);
          mTick[e][i] = 1'b0;
          if (ps == 0 || mSrc[e][i] == 0) begin
            mSrc[e][i] = ps; mCode[e][i] = pc; mCnt[e][i] = 0;
          end else if (srcOf(mSrc[e][i], auxTick, genTick)) begin
            if (mCnt[e][i] == ratioOf(mCode[e][i], e) - 1) begin
              mTick[e][i] = 1'b1; mCnt[e][i] = 0; mSrc[e][i] = ps; mCode[e][i] = pc;
            end else begin
              mCnt[e][i]++;
            end
          end
        end
        rnd = (int'(reqRatio) + 8) >> 4;
        rej = (rnd == 0) || (rnd > 4) || (reqSel > 3'd5);
        mErr[e] = reqValid && rej;
        if (wrEn) mReg[e] = wrData;
        else if (reqValid && !rej) mReg[e][int'(reqSel)*5 +: 2] = 2'(codeOf(rnd, e));
      end
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [5:0] expEn [2];
    for (int e = 0; e < 2; e++)
      for (int i = 0; i < 6; i++) expEn[e][i] = |mReg[e][i*5+2 +: 3];
    cmp("ext rdData", rdX, mReg[1]);
    cmp("std rdData", rdS, mReg[0]);
    cmp("ext reqErr", 32'(errX), 32'(mErr[1]));
    cmp("std reqErr", 32'(errS), 32'(mErr[0]));
    cmp("ext consEnabled(R4)", 32'(enX), 32'(expEn[1]));
    cmp("std consEnabled(R4)", 32'(enS), 32'(expEn[0]));
    cmp("ext consTick(R5,R12)", 32'(tkX), 32'(mTick[1]));
    cmp("std consTick(R5,R12)", 32'(tkS), 32'(mTick[0]));
  endtask

  // Advance one cycle: compare outputs, then drive fresh inputs
  task automatic step(input int density);
    @(negedge clk);
    if (live) compareAll();
    wrEn = 1'b0; reqValid = 1'b0;
    auxTick = ($urandom % 100) < density;
    for (int g = 0; g < 6; g++) genTick[g] = ($urandom % 100) < density;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0);
    live = 1'b1;
    // R1: reset state
    curReq = "R1";
    cmp("reset rdData", rdX, 32'd0);
    cmp("reset ticks", 32'({tkX, tkS}), 32'd0);
    cmp("reset enables", 32'({enX, enS}), 32'd0);
    cmp("reset err", 32'({errX, errS}), 32'd0);

    // R2 R3 R4 R5 R12: every source with every divide code on all consumers
    curReq = "R2 R3 R4 R5 R12";
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] w;
        w = {2'b10, 30'd0};
        for (int i = 0; i < 6; i++) w[i*5 +: 5] = {3'(s), 2'(c)};
        step(60);
        wrEn = 1'b1; wrData = w;
        repeat (40) step(60);
      end
    end

    // R6 R7: random field changes at random spacing, including mid-count
    curReq = "R6 R7";
    for (int k = 0; k < 300; k++) begin
      step(50);
      wrEn = 1'b1; wrData = $urandom;
      repeat (1 + ($urandom % 12)) step(50);
    end

    // R8 R9 R10: every ratio against every selector value
    curReq = "R8 R9 R10";
    for (int sel = 0; sel < 8; sel++) begin
      step(30);
      wrEn = 1'b1; wrData = $urandom;
      for (int r = 0; r < 256; r++) begin
        step(30);
        reqValid = 1'b1; reqSel = 3'(sel); reqRatio = 8'(r);
        step(30);
      end
    end

    // R11: write and request in the same cycle
    curReq = "R11";
    for (int k = 0; k < 200; k++) begin
      step(40);
      wrEn = 1'b1; wrData = $urandom;
      reqValid = 1'b1; reqSel = 3'($urandom % 8); reqRatio = 8'($urandom);
    end
    repeat (4) step(40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule